// File: doc/BRIEF.md
# Serial Converter Command Port

This block is the device side of the serial port on an 8-bit multi-channel sampling converter. A host drives chip select, a serial clock and serial data. The port waits for a start bit and then assembles an 8-bit command. It decodes the channel, polarity, input-pairing, power and clock-mode fields of that command. It also issues the track and hold events of the sampling front end at fixed serial-clock edges.

The analog path and the successive-approximation engine are outside the block. The engine receives a one-cycle request with the decoded fields and answers with a one-cycle result strobe that carries the 8-bit code. When the converter is clocked by the host, the port produces a strobe pulse and shifts the code out on the serial output. When the converter runs on its own clock, the strobe marks the busy interval instead.

A new command may overlap the readout of the previous result, so one conversion can take as few as ten serial clocks. Raising chip select in the middle of a host-clocked conversion cancels it. All serial inputs are brought into the fast system clock through synchronizers, and every edge becomes a single-cycle event.

Top module: `adc_ctrl_frontend`

## Requirements
- R1: While chip select is low, the port samples serial data on each rising serial-clock edge. Any leading 0 bits are discarded, and the first 1 becomes bit 7 of the command. The remaining seven bits follow it, MSB first.
- R2: The command fields are decoded as follows. Bits [6:4] select the channel. Bit 3 set means unipolar. Bit 2 set means single-ended. Bit 1 set means powered up. Bit 0 set means the host clocks the conversion. On the falling edge after bit 0 arrives, the fields are registered onto the cfg outputs and conv_req pulses high for exactly one system-clock cycle.
- R3: track_start pulses for one cycle on the falling edge that follows the sixth command bit. It never coincides with conv_req or conv_abort.
- R4: When the host clocks the conversion, strobe rises on the falling edge that ends the command. It falls on the second falling edge after that.
- R5: When the host clocks the conversion, the result MSB appears on sdo at the second falling edge after the command ends. One further bit follows on each falling edge, and zeros follow after the LSB. Before any result exists, sdo shifts out zeros.
- R6: sdo_oe is low whenever chip select is high. When the host clocks the conversion, strobe_oe is also low whenever chip select is high, and strobe is driven 0 after chip select falls. In this mode sdo and strobe change only on falling serial-clock edges, or when a conversion is cancelled.
- R7: A 1 on serial data is taken as a start bit only if no readout is pending or the result MSB is already out, and no self-clocked conversion is busy. This lets a new command begin on the eleventh clock of a frame.
- R8: Raising chip select while a host-clocked conversion has not yet shifted out its LSB produces a one-cycle conv_abort pulse. It cancels the readout and clears the output register, and the next 1 bit begins a new command.
- R9: When the converter runs on its own clock, strobe is driven low from the end of the command until the result arrives, and then high. strobe_oe stays high even with chip select high. The result MSB appears on the second falling edge after the result arrives.
- R10: After reset the port is in self-clocked mode, with strobe driven high and sdo_oe low. No event pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select (asynchronous) |
| sclk | input | 1 | Serial clock (asynchronous) |
| sdi | input | 1 | Serial command data (asynchronous) |
| sdo | output | 1 | Serial result data value |
| sdo_oe | output | 1 | Output enable for sdo |
| strobe | output | 1 | Strobe value |
| strobe_oe | output | 1 | Output enable for strobe |
| conv_req | output | 1 | One-cycle conversion request to the engine |
| track_start | output | 1 | One-cycle pulse: sampling front end starts tracking |
| conv_abort | output | 1 | One-cycle pulse: host-clocked conversion cancelled |
| cfg_chan | output | 3 | Selected channel |
| cfg_unipolar | output | 1 | 1 = unipolar, 0 = bipolar |
| cfg_single | output | 1 | 1 = single-ended, 0 = differential |
| cfg_pwr_up | output | 1 | 1 = powered up, 0 = power-down |
| cfg_ext_clk | output | 1 | 1 = host-clocked conversion, 0 = self-clocked |
| res_valid | input | 1 | One-cycle strobe from the engine: result ready |
| res_data | input | 8 | Conversion code from the engine |

## Verification
An input edge passes through two synchronizer stages and one edge-detect register, so every response is registered on the third system-clock edge after the serial pin changes. The bench holds each serial-clock level for eight system cycles and compares all outputs against its reference model on the falling system edge after the eighth cycle, which leaves a margin of five cycles. Results from the self-clocked engine come roughly forty cycles after the request. The bench therefore waits sixty idle cycles before it expects the strobe to rise and the readout count to restart.

// File: rtl/adc_fe_pkg.sv
package adc_fe_pkg;

  localparam int CMD_W = 8;
  localparam int CODE_W = 8;

  typedef struct packed {
    logic [2:0] chan;
    logic       unipolar;
    logic       single;
    logic       pwr_up;
    logic       ext_clk;
  } cmd_fields_t;

  // Split the seven payload bits that follow the start bit.
  function automatic cmd_fields_t unpack_cmd(input logic [CMD_W-2:0] payload);
    cmd_fields_t f;
    f.chan     = payload[6:4];
    f.unipolar = payload[3];
    f.single   = payload[2];
    f.pwr_up   = payload[1];
    f.ext_clk  = payload[0];
    return f;
  endfunction

  // Counter step that stops at a ceiling.
  function automatic logic [3:0] step_sat(input logic [3:0] v, input logic [3:0] ceil);
    return (v < ceil) ? v + 4'd1 : v;
  endfunction

endpackage

// File: rtl/adc_fe_sync.sv
module adc_fe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic cs_active,
  output logic sdi_s,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_rise,
  output logic cs_fall
);
  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] IDLE_VAL = 3'b100; // {cs_n, sclk, sdi}

  logic [STAGES-1:0][NSIG-1:0] pipe;
  logic [NSIG-1:0] prev;
  logic [NSIG-1:0] cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= {STAGES{IDLE_VAL}};
      prev <= IDLE_VAL;
    end else begin
      pipe[0] <= {cs_n, sclk, sdi};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      prev <= pipe[STAGES-1];
    end
  end

  assign cur       = pipe[STAGES-1];
  assign cs_active = ~cur[2];
  assign sdi_s     = cur[0];
  assign sclk_rise = cur[1] & ~prev[1];
  assign sclk_fall = ~cur[1] & prev[1];
  assign cs_rise   = cur[2] & ~prev[2];
  assign cs_fall   = ~cur[2] & prev[2];
endmodule

// File: rtl/adc_fe_capture.sv
module adc_fe_capture
  import adc_fe_pkg::*;
#(
  parameter int TRACK_AT = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_active,
  input  logic        sclk_rise,
  input  logic        sclk_fall,
  input  logic        sdi_s,
  input  logic        start_ok,
  output logic        hold_now,
  output logic        hold_ext,
  output logic        start_evt,
  output logic        track_q,
  output logic        req_q,
  output cmd_fields_t fields_q
);
  localparam int CNT_W = $clog2(CMD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] TRK  = CNT_W'(TRACK_AT);

  logic [CNT_W-1:0] nbits;
  logic [CMD_W-1:0] cmd;

  // R1: first 1 while hunting (and allowed) opens a command
  assign start_evt = cs_active && sclk_rise && (nbits == '0) && start_ok && sdi_s;
  assign hold_now  = cs_active && sclk_fall && (nbits == FULL);
  assign hold_ext  = cmd[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nbits    <= '0;
      cmd      <= '0;
      track_q  <= 1'b0;
      req_q    <= 1'b0;
      fields_q <= '0;
    end else begin
      track_q <= cs_active && sclk_fall && (nbits == TRK);
      req_q   <= hold_now;
      if (hold_now) fields_q <= unpack_cmd(cmd[CMD_W-2:0]);
      if (!cs_active) begin
        nbits <= '0;
      end else if (start_evt) begin
        nbits <= CNT_W'(1);
        cmd   <= CMD_W'(1);
      end else if (sclk_rise && nbits != '0 && nbits < FULL) begin
        nbits <= nbits + CNT_W'(1);
        cmd   <= {cmd[CMD_W-2:0], sdi_s};
      end else if (hold_now) begin
        nbits <= '0;
      end
    end
  end
endmodule

// File: rtl/adc_fe_readout.sv
module adc_fe_readout
  import adc_fe_pkg::*;
#(
  parameter int MSB_AT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_active,
  input  logic              sclk_fall,
  input  logic              cs_rise,
  input  logic              cs_fall,
  input  logic              hold_now,
  input  logic              hold_ext,
  input  logic              res_valid,
  input  logic [CODE_W-1:0] res_data,
  output logic              sdo_bit,
  output logic              strobe_bit,
  output logic              ext_mode,
  output logic              start_ok,
  output logic              abort_q
);
  localparam logic [3:0] MSB_CNT  = 4'(MSB_AT);
  localparam logic [3:0] DONE_CNT = 4'(MSB_AT + CODE_W);

  logic              rd_act;
  logic [3:0]        rd_cnt;
  logic [CODE_W-1:0] shreg;
  logic [CODE_W-1:0] code_q;
  logic              int_busy;
  logic              abort_now;
  logic              msb_fall;

  assign msb_fall   = rd_act && (rd_cnt == MSB_CNT);
  // R7: start accepted once the MSB is out and no self-clocked conversion runs
  assign start_ok   = !int_busy && !(rd_act && rd_cnt <= MSB_CNT);
  // R8: host-clocked conversion cancelled before its LSB
  assign abort_now  = cs_rise && ext_mode && rd_act && (rd_cnt < DONE_CNT);
  assign sdo_bit    = shreg[CODE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act     <= 1'b0;
      rd_cnt     <= '0;
      shreg      <= '0;
      code_q     <= '0;
      int_busy   <= 1'b0;
      ext_mode   <= 1'b0;
      strobe_bit <= 1'b1;
      abort_q    <= 1'b0;
    end else begin
      abort_q <= abort_now;
      if (res_valid) code_q <= res_data;
      if (abort_now) begin
        rd_act     <= 1'b0;
        shreg      <= '0;
        strobe_bit <= 1'b0;
      end else if (cs_fall && ext_mode) begin
        strobe_bit <= 1'b0;
      end else if (sclk_fall && cs_active) begin
        shreg <= msb_fall ? code_q : {shreg[CODE_W-2:0], 1'b0};
        if (rd_act) rd_cnt <= step_sat(rd_cnt, DONE_CNT);
        if (msb_fall && ext_mode) strobe_bit <= 1'b0;
        if (hold_now) begin
          ext_mode <= hold_ext;
          rd_cnt   <= '0;
          if (hold_ext) begin
            rd_act     <= 1'b1;
            int_busy   <= 1'b0;
            strobe_bit <= 1'b1;
          end else begin
            rd_act     <= 1'b0;
            int_busy   <= 1'b1;
            strobe_bit <= 1'b0;
          end
        end
      end
      // R9: self-clocked result arrival opens the readout
      if (res_valid && int_busy) begin
        int_busy   <= 1'b0;
        strobe_bit <= 1'b1;
        rd_act     <= 1'b1;
        rd_cnt     <= '0;
      end
    end
  end
endmodule

// File: rtl/adc_ctrl_frontend.sv
module adc_ctrl_frontend
  import adc_fe_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TRACK_AT    = 6,
  parameter int MSB_AT      = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              strobe,
  output logic              strobe_oe,
  output logic              conv_req,
  output logic              track_start,
  output logic              conv_abort,
  output logic [2:0]        cfg_chan,
  output logic              cfg_unipolar,
  output logic              cfg_single,
  output logic              cfg_pwr_up,
  output logic              cfg_ext_clk,
  input  logic              res_valid,
  input  logic [CODE_W-1:0] res_data
);
  logic cs_active, sdi_s, sclk_rise, sclk_fall, cs_rise, cs_fall;
  logic hold_now, hold_ext, start_evt, start_ok, ext_mode;
  cmd_fields_t fields;

  adc_fe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .cs_active(cs_active), .sdi_s(sdi_s), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .cs_rise(cs_rise), .cs_fall(cs_fall)
  );

  adc_fe_capture #(.TRACK_AT(TRACK_AT)) u_cap (
    .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .sdi_s(sdi_s), .start_ok(start_ok),
    .hold_now(hold_now), .hold_ext(hold_ext), .start_evt(start_evt),
    .track_q(track_start), .req_q(conv_req), .fields_q(fields)
  );

  adc_fe_readout #(.MSB_AT(MSB_AT)) u_rd (
    .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .sclk_fall(sclk_fall),
    .cs_rise(cs_rise), .cs_fall(cs_fall), .hold_now(hold_now),
    .hold_ext(hold_ext), .res_valid(res_valid), .res_data(res_data),
    .sdo_bit(sdo), .strobe_bit(strobe), .ext_mode(ext_mode),
    .start_ok(start_ok), .abort_q(conv_abort)
  );

  assign sdo_oe       = cs_active;
  assign strobe_oe    = !ext_mode || cs_active;
  assign cfg_chan     = fields.chan;
  assign cfg_unipolar = fields.unipolar;
  assign cfg_single   = fields.single;
  assign cfg_pwr_up   = fields.pwr_up;
  assign cfg_ext_clk  = fields.ext_clk;
endmodule

// File: rtl/adc_ctrl_frontend_chk.sv
module adc_ctrl_frontend_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk_fall,
  input logic cs_rise,
  input logic cs_fall,
  input logic ext_mode,
  input logic sdo,
  input logic strobe,
  input logic conv_req,
  input logic track_start,
  input logic conv_abort
);
  AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_fall && !cs_rise) |=> $stable(sdo)); // R6
  AST_STRB_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && !sclk_fall && !cs_rise && !cs_fall) |=> $stable(strobe)); // R6
  AST_REQ_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> $past(sclk_fall)); // R2
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req); // R2
  AST_TRACK_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    track_start |-> $past(sclk_fall)); // R3
  AST_EVENTS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({conv_req, track_start, conv_abort})); // R3
  AST_ABORT_ON_CS: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort |-> $past(cs_rise)); // R8
endmodule

bind adc_ctrl_frontend adc_ctrl_frontend_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_fall(sclk_fall), .cs_rise(cs_rise),
  .cs_fall(cs_fall), .ext_mode(ext_mode), .sdo(sdo), .strobe(strobe),
  .conv_req(conv_req), .track_start(track_start), .conv_abort(conv_abort)
);

// File: tb/adc_ctrl_frontend_tb.sv
module adc_ctrl_frontend_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe, strobe, strobe_oe, conv_req, track_start, conv_abort;
  logic [2:0] cfg_chan;
  logic cfg_unipolar, cfg_single, cfg_pwr_up, cfg_ext_clk;
  logic res_valid = 1'b0;
  logic [7:0] res_data = '0;

  always #4 clk = ~clk; // 125 MHz

  adc_ctrl_frontend u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .strobe(strobe), .strobe_oe(strobe_oe),
    .conv_req(conv_req), .track_start(track_start), .conv_abort(conv_abort),
    .cfg_chan(cfg_chan), .cfg_unipolar(cfg_unipolar), .cfg_single(cfg_single),
    .cfg_pwr_up(cfg_pwr_up), .cfg_ext_clk(cfg_ext_clk),
    .res_valid(res_valid), .res_data(res_data)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int cnt_req = 0, cnt_trk = 0, cnt_abt = 0;

  function automatic logic [7:0] code_of(input logic [7:0] c);
    return c * 8'd37 + 8'd11;
  endfunction

  // behavioural conversion engine
  int eng_wait = 0;
  logic [7:0] eng_cmd = '0;
  always @(posedge clk) begin
    res_valid <= 1'b0;
    if (eng_wait > 0) begin
      eng_wait <= eng_wait - 1;
      if (eng_wait == 1) begin
        res_valid <= 1'b1;
        res_data  <= code_of(eng_cmd);
      end
    end
    if (conv_req) begin
      eng_cmd  <= {1'b1, cfg_chan, cfg_unipolar, cfg_single, cfg_pwr_up, cfg_ext_clk};
      eng_wait <= cfg_ext_clk ? 3 : 40;
    end
  end

  always @(posedge clk) if (rst_n) begin
    if (conv_req) cnt_req++;
    if (track_start) cnt_trk++;
    if (conv_abort) cnt_abt++;
  end

  // reference model state
  int m_cap = 0, m_cnt = 0, m_req = 0, m_trk = 0, m_abt = 0;
  logic [7:0] m_cmd = '0, m_sh = '0, m_res = '0, m_pend = '0;
  bit m_cs = 1, m_ext = 0, m_rd = 0, m_busy = 0, m_strb = 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    bit soe = !m_ext || !m_cs;
    chk(sdo_oe == !m_cs, "R6", "sdo_oe", sdo_oe, !m_cs);
    if (!m_cs) chk(sdo == m_sh[7], "R5", "sdo", sdo, m_sh[7]);
    chk(strobe_oe == soe, "R6", "strobe_oe", strobe_oe, soe);
    if (soe) chk(strobe == m_strb, m_ext ? "R4" : "R9", "strobe", strobe, m_strb);
    chk(cnt_req == m_req, "R2", "requests", cnt_req, m_req);
    chk(cnt_trk == m_trk, "R3", "track pulses", cnt_trk, m_trk);
    chk(cnt_abt == m_abt, "R8", "aborts", cnt_abt, m_abt);
  endtask

  task automatic settle();
    repeat (8) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic m_rise(input bit b);
    bit ok = !m_busy && !(m_rd && m_cnt <= 1);
    if (m_cs) return;
    if (m_cap == 0) begin
      if (ok && b) begin m_cap = 1; m_cmd = 8'd1; end
    end else if (m_cap < 8) begin
      m_cmd = {m_cmd[6:0], b}; m_cap++;
    end
  endtask

  task automatic m_fall();
    bit msb;
    if (m_cs) return;
    if (m_cap == 6) m_trk++;
    msb = m_rd && m_cnt == 1;
    m_sh = msb ? m_res : {m_sh[6:0], 1'b0};
    if (msb && m_ext) m_strb = 0;
    if (m_rd && m_cnt < 9) m_cnt++;
    if (m_cap == 8) begin
      m_cap = 0; m_req++; m_ext = m_cmd[0]; m_cnt = 0;
      if (m_ext) begin m_rd = 1; m_strb = 1; m_busy = 0; m_res = code_of(m_cmd); end
      else begin m_rd = 0; m_strb = 0; m_busy = 1; m_pend = code_of(m_cmd); end
    end
  endtask

  task automatic clk_bit(input bit b);
    sdi = b; sclk = 1'b1; m_rise(b); settle(); compare();
    sclk = 1'b0; m_fall(); settle(); compare();
  endtask

  task automatic send(input logic [7:0] c);
    for (int i = 7; i >= 0; i--) clk_bit(c[i]);
  endtask

  task automatic zeros(input int n);
    for (int i = 0; i < n; i++) clk_bit(1'b0);
  endtask

  task automatic set_cs(input bit v);
    cs_n = v;
    if (v) begin
      if (m_ext && m_rd && m_cnt < 9) begin m_abt++; m_rd = 0; m_sh = '0; m_strb = 0; end
      m_cap = 0;
    end else if (m_ext) m_strb = 0;
    m_cs = v;
    settle(); compare();
  endtask

  task automatic idle_for_result();
    repeat (60) @(posedge clk);
    @(negedge clk);
    if (m_busy) begin m_busy = 0; m_strb = 1; m_rd = 1; m_cnt = 0; m_res = m_pend; end
    compare();
  endtask

  task automatic check_cfg(input logic [7:0] c, input string req);
    chk(cfg_chan == c[6:4], req, "cfg_chan", cfg_chan, c[6:4]);
    chk({cfg_unipolar, cfg_single, cfg_pwr_up, cfg_ext_clk} == c[3:0], req,
        "cfg flags", {cfg_unipolar, cfg_single, cfg_pwr_up, cfg_ext_clk}, c[3:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    settle();
    // R10: reset state
    chk(strobe == 1'b1 && strobe_oe == 1'b1, "R10", "strobe driven high", strobe, 1);
    chk(sdo_oe == 1'b0, "R10", "sdo_oe", sdo_oe, 0);
    chk(cfg_ext_clk == 1'b0 && cnt_req == 0, "R10", "mode/requests", cfg_ext_clk, 0);
    compare();

    // R1: leading zeros ignored, then host-clocked command
    set_cs(1'b0);
    zeros(3);
    chk(cnt_req == 0, "R1", "no request from zeros", cnt_req, 0);
    send(8'hDB);
    check_cfg(8'hDB, "R2");
    zeros(11);

    // R7: back-to-back ten-clock conversions; early 1s ignored
    send(8'hF7);
    check_cfg(8'hF7, "R2");
    clk_bit(1'b1); clk_bit(1'b1);
    send(8'h8F);
    check_cfg(8'h8F, "R7");
    zeros(11);

    // R8: cancel mid-conversion, then restart
    send(8'hA3);
    zeros(1);
    set_cs(1'b1);
    set_cs(1'b0);
    send(8'h9B);
    check_cfg(8'h9B, "R8");
    zeros(11);

    // R9: self-clocked conversion and readout
    send(8'hCE);
    check_cfg(8'hCE, "R9");
    idle_for_result();
    zeros(11);
    set_cs(1'b1);
    chk(strobe_oe == 1'b1, "R9", "strobe_oe with cs high", strobe_oe, 1);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule